// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Vector Generator

This block sits between a pair of cascaded eight-line interrupt controllers and the processor. It holds the per-line request latches, in-service bits, trigger-mode selection and rotating priority base for both controllers. The secondary controller's "interrupt wanted" condition is fed into line 2 of the primary controller. The block raises a single interrupt output toward the processor.

When the processor pulses the acknowledge input, the block resolves the winning line on the primary controller. If that winner is the cascade line, it also resolves the secondary controller. It then updates the request and in-service state of whichever controller owns the winner, and returns an 8-bit vector one cycle later with a valid strobe. A poll request selects one controller and returns its winning line in a flagged format, with no vector base. The poll acknowledges that line exactly as a normal acknowledge would.

Vector bases, line masks, auto-EOI and rotate-on-auto-EOI come in as static configuration inputs. Only the trigger-mode registers are written through the block.

Top module: `ivg_ack_vector`

## Requirements
- R1: While reset is held and in the first cycle after it, `int_o`, `vec_valid_o` and `vec_o` are all 0, and every request, in-service and rotation register is cleared.
- R2: A one-cycle `ack_i` or `poll_i` pulse makes `vec_valid_o` high for exactly the following cycle, with `vec_o` valid in that cycle. Without a pulse, `vec_valid_o` is low and `vec_o` holds its value. For a primary winner that is not line 2, the vector is `{m_base_i, line}`.
- R3: Each controller picks as winner the first pending, unmasked line found by scanning upward from its rotation base, wrapping modulo 8. The winner is valid only if no in-service line is found earlier or at the same position in that scan. An in-service line therefore blocks its own and lower-priority lines, but not higher-priority ones.
- R4: If the primary controller has no valid winner at acknowledge, the vector is `{m_base_i, 3'd7}` and no register changes.
- R5: If the primary winner is line 2, the secondary is resolved and the vector is `{s_base_i, slave_line}`. The acknowledge updates line 2 on the primary and the winning line on the secondary.
- R6: If the primary winner is line 2 but the secondary has no valid winner, the vector is `{s_base_i, 3'd7}` and the secondary is left unchanged.
- R7: On acknowledge, an edge-triggered line's request latch is cleared. A level-triggered line's request follows its input and stays set while the input is high. Edge lines latch on a 0-to-1 input transition.
- R8: With auto-EOI enabled for a controller (`aeoi_i` bit 0 primary, bit 1 secondary), acknowledging never sets an in-service bit. Without auto-EOI, the acknowledged line's in-service bit is set.
- R9: With auto-EOI and rotate-on-auto-EOI (`rot_aeoi_i`, same bit order) both set, an acknowledge makes the rotation base the acknowledged line plus one, modulo 8.
- R10: `tm_we_i` writes `tm_wdata_i` into the trigger-mode register selected by `tm_sel_i` (0 primary, 1 secondary). Bit i set means line i is level-triggered. The stored value is masked by 0xF8 on the primary and 0xDE on the secondary.
- R11: A poll with `ack_i` low returns `8'h80 | line` for the selected controller's valid winner, acknowledging it as in R7–R9, or returns `8'h07` when there is no valid winner. When `ack_i` and `poll_i` are high together, the acknowledge is performed and the poll is ignored.
- R12: `int_o` is high one cycle after the primary controller has a valid winner, so any acknowledge or poll is reflected on it in the second cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 16 | Request inputs; bits 7:0 primary, 15:8 secondary; bit 2 unused (cascade) |
| m_imr_i | input | 8 | Primary line mask, 1 = masked |
| s_imr_i | input | 8 | Secondary line mask, 1 = masked |
| m_base_i | input | 5 | Primary vector base (upper five vector bits) |
| s_base_i | input | 5 | Secondary vector base (upper five vector bits) |
| aeoi_i | input | 2 | Auto-EOI enable, bit 0 primary, bit 1 secondary |
| rot_aeoi_i | input | 2 | Rotate on auto-EOI, bit 0 primary, bit 1 secondary |
| tm_we_i | input | 1 | Trigger-mode write enable |
| tm_sel_i | input | 1 | Trigger-mode register select, 0 primary, 1 secondary |
| tm_wdata_i | input | 8 | Trigger-mode write data, 1 = level |
| ack_i | input | 1 | Acknowledge pulse |
| poll_i | input | 1 | Poll pulse |
| poll_sel_i | input | 1 | Poll target, 0 primary, 1 secondary |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector or poll result |
| vec_valid_o | output | 1 | `vec_o` valid strobe |

## Verification
A corrupted request latch, in-service bit or rotation base shows at the ports in two ways. It alters `int_o` two cycles after the event that caused it, and it alters the next vector returned, so each scenario follows an acknowledge with a second acknowledge or poll to expose the left-over state. Trigger-mode masking is visible only through whether a held line reappears after being acknowledged, so repeated polls of the same controller stand in for a readback. The cascade's latched line 2 can outlive the secondary request that set it, which is how a secondary spurious vector is provoked within a few cycles.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
    localparam int LINES  = 8;
    localparam int LINE_W = $clog2(LINES);
    localparam int VEC_W  = 8;
    localparam int BASE_W = VEC_W - LINE_W;
    localparam int N_CTL  = 2;

    localparam logic [LINES-1:0]  PRI_TM_ALLOW = 8'hF8;
    localparam logic [LINES-1:0]  SEC_TM_ALLOW = 8'hDE;
    localparam logic [LINE_W-1:0] CASCADE_LINE = LINE_W'(2);
    localparam logic [LINE_W-1:0] SPUR_LINE    = LINE_W'(LINES - 1);
    localparam logic [VEC_W-1:0]  POLL_FLAG    = VEC_W'(8'h80);

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
    } win_t;

    function automatic logic [VEC_W-1:0] make_vec(logic [BASE_W-1:0] base,
                                                 logic [LINE_W-1:0] line);
        return {base, line};
    endfunction
endpackage

// File: rtl/ivg_arbiter.sv
module ivg_arbiter
    import ivg_pkg::*;
(
    input  logic [LINES-1:0]  pend_i,
    input  logic [LINES-1:0]  isr_i,
    input  logic [LINE_W-1:0] rot_i,
    output win_t              win_o
);
    logic [LINE_W:0]   req_pos;
    logic [LINE_W:0]   svc_pos;
    logic [LINE_W-1:0] idx;

    always_comb begin
        req_pos = (LINE_W+1)'(LINES);
        svc_pos = (LINE_W+1)'(LINES);
        idx     = '0;
        for (int p = LINES - 1; p >= 0; p--) begin
            idx = rot_i + LINE_W'(p);
            if (pend_i[idx]) req_pos = (LINE_W+1)'(p);
            if (isr_i[idx])  svc_pos = (LINE_W+1)'(p);
        end
        win_o.valid = (req_pos < svc_pos);
        win_o.line  = rot_i + req_pos[LINE_W-1:0];
    end
endmodule

// File: rtl/ivg_ctl_bank.sv
module ivg_ctl_bank
    import ivg_pkg::*;
#(
    parameter logic [LINES-1:0] TM_ALLOW = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  lvl_i,
    input  logic              tm_we_i,
    input  logic [LINES-1:0]  tm_wdata_i,
    input  logic              aeoi_i,
    input  logic              rot_en_i,
    input  logic              take_i,
    input  logic [LINE_W-1:0] take_line_i,
    output logic [LINES-1:0]  irr_o,
    output logic [LINES-1:0]  isr_o,
    output logic [LINE_W-1:0] rot_o
);
    logic [LINES-1:0]  tm_q, last_q, irr_q, isr_q;
    logic [LINE_W-1:0] rot_q;
    logic [LINES-1:0]  irr_d, isr_d;
    logic [LINE_W-1:0] rot_d;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            if (tm_q[i]) irr_d[i] = lvl_i[i];
            else         irr_d[i] = irr_q[i] | (lvl_i[i] & ~last_q[i]);
        end
        isr_d = isr_q;
        rot_d = rot_q;
        if (take_i) begin
            if (!tm_q[take_line_i]) irr_d[take_line_i] = 1'b0;
            if (aeoi_i) begin
                if (rot_en_i) rot_d = take_line_i + LINE_W'(1);
            end else begin
                isr_d[take_line_i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q   <= '0;
            last_q <= '0;
            irr_q  <= '0;
            isr_q  <= '0;
            rot_q  <= '0;
        end else begin
            if (tm_we_i) tm_q <= tm_wdata_i & TM_ALLOW;
            last_q <= lvl_i;
            irr_q  <= irr_d;
            isr_q  <= isr_d;
            rot_q  <= rot_d;
        end
    end

    assign irr_o = irr_q;
    assign isr_o = isr_q;
    assign rot_o = rot_q;
endmodule

// File: rtl/ivg_ack_vector.sv
module ivg_ack_vector
    import ivg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_CTL*LINES-1:0]  irq_i,
    input  logic [LINES-1:0]        m_imr_i,
    input  logic [LINES-1:0]        s_imr_i,
    input  logic [BASE_W-1:0]       m_base_i,
    input  logic [BASE_W-1:0]       s_base_i,
    input  logic [N_CTL-1:0]        aeoi_i,
    input  logic [N_CTL-1:0]        rot_aeoi_i,
    input  logic                    tm_we_i,
    input  logic                    tm_sel_i,
    input  logic [LINES-1:0]        tm_wdata_i,
    input  logic                    ack_i,
    input  logic                    poll_i,
    input  logic                    poll_sel_i,
    output logic                    int_o,
    output logic [VEC_W-1:0]        vec_o,
    output logic                    vec_valid_o
);
    logic [N_CTL-1:0][LINES-1:0]  lvl, irr, isr, imr, pend;
    logic [N_CTL-1:0][LINE_W-1:0] rot, take_line;
    logic [N_CTL-1:0][BASE_W-1:0] base;
    logic [N_CTL-1:0]             take;
    win_t [N_CTL-1:0]             win;
    logic [VEC_W-1:0]             vec_d, vec_q;
    logic                         fire, valid_q, int_q;

    assign imr  = {s_imr_i, m_imr_i};
    assign base = {s_base_i, m_base_i};
    assign fire = ack_i | poll_i;

    always_comb begin
        lvl[0] = irq_i[LINES-1:0];
        lvl[0][CASCADE_LINE] = win[1].valid;
        lvl[1] = irq_i[2*LINES-1:LINES];
    end

    for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
        assign pend[c] = irr[c] & ~imr[c];

        ivg_ctl_bank #(
            .TM_ALLOW (c == 0 ? PRI_TM_ALLOW : SEC_TM_ALLOW)
        ) u_bank (
            .clk         (clk),
            .rst         (rst),
            .lvl_i       (lvl[c]),
            .tm_we_i     (tm_we_i && (tm_sel_i == 1'(c))),
            .tm_wdata_i  (tm_wdata_i),
            .aeoi_i      (aeoi_i[c]),
            .rot_en_i    (rot_aeoi_i[c]),
            .take_i      (take[c]),
            .take_line_i (take_line[c]),
            .irr_o       (irr[c]),
            .isr_o       (isr[c]),
            .rot_o       (rot[c])
        );

        ivg_arbiter u_arb (
            .pend_i (pend[c]),
            .isr_i  (isr[c]),
            .rot_i  (rot[c]),
            .win_o  (win[c])
        );
    end

    always_comb begin
        take      = '0;
        take_line = '0;
        vec_d     = vec_q;
        if (ack_i) begin
            if (!win[0].valid) begin
                vec_d = make_vec(base[0], SPUR_LINE);
            end else begin
                take[0]      = 1'b1;
                take_line[0] = win[0].line;
                if (win[0].line != CASCADE_LINE) begin
                    vec_d = make_vec(base[0], win[0].line);
                end else if (win[1].valid) begin
                    take[1]      = 1'b1;
                    take_line[1] = win[1].line;
                    vec_d        = make_vec(base[1], win[1].line);
                end else begin
                    vec_d = make_vec(base[1], SPUR_LINE);
                end
            end
        end else if (poll_i) begin
            if (win[poll_sel_i].valid) begin
                take[poll_sel_i]      = 1'b1;
                take_line[poll_sel_i] = win[poll_sel_i].line;
                vec_d = POLL_FLAG | VEC_W'(win[poll_sel_i].line);
            end else begin
                vec_d = VEC_W'(SPUR_LINE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q   <= '0;
            valid_q <= 1'b0;
            int_q   <= 1'b0;
        end else begin
            if (fire) vec_q <= vec_d;
            valid_q <= fire;
            int_q   <= win[0].valid;
        end
    end

    assign int_o       = int_q;
    assign vec_o       = vec_q;
    assign vec_valid_o = valid_q;
endmodule

// File: rtl/ivg_checker.sv
module ivg_checker
    import ivg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ack_i,
    input logic              poll_i,
    input logic [BASE_W-1:0] m_base_i,
    input logic [N_CTL-1:0]  aeoi_i,
    input logic [N_CTL-1:0]  rot_aeoi_i,
    input logic [VEC_W-1:0]  vec_o,
    input logic              vec_valid_o,
    input logic              int_o,
    input win_t              win_m,
    input logic [LINES-1:0]  isr_m,
    input logic [LINE_W-1:0] rot_m
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!vec_valid_o && !int_o && vec_o == '0));

    assert_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (ack_i || poll_i) |=> vec_valid_o);

    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !(ack_i || poll_i) |=> (!vec_valid_o && $stable(vec_o)));

    assert_spurious_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !win_m.valid) |=>
            (vec_o[LINE_W-1:0] == SPUR_LINE && vec_o[VEC_W-1:LINE_W] == $past(m_base_i)));

    assert_aeoi_R8: assert property (@(posedge clk) disable iff (rst)
        aeoi_i[0] |=> ((isr_m & ~$past(isr_m)) == '0));

    assert_rotate_R9: assert property (@(posedge clk) disable iff (rst)
        (ack_i && win_m.valid && aeoi_i[0] && rot_aeoi_i[0]) |=>
            (rot_m == $past(win_m.line) + LINE_W'(1)));

    assert_poll_fmt_R11: assert property (@(posedge clk) disable iff (rst)
        (poll_i && !ack_i) |=> (vec_o[VEC_W-2:LINE_W] == '0));
endmodule

bind ivg_ack_vector ivg_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack_i       (ack_i),
    .poll_i      (poll_i),
    .m_base_i    (m_base_i),
    .aeoi_i      (aeoi_i),
    .rot_aeoi_i  (rot_aeoi_i),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o),
    .int_o       (int_o),
    .win_m       (win[0]),
    .isr_m       (isr[0]),
    .rot_m       (rot[0])
);

// File: tb/sim_ivg_ack_vector.sv
module sim_ivg_ack_vector;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_i = '0;
    logic [7:0]  m_imr_i = '0, s_imr_i = '0;
    logic [4:0]  m_base_i = 5'h01, s_base_i = 5'h0E;
    logic [1:0]  aeoi_i = '0, rot_aeoi_i = '0;
    logic        tm_we_i = 1'b0, tm_sel_i = 1'b0;
    logic [7:0]  tm_wdata_i = '0;
    logic        ack_i = 1'b0, poll_i = 1'b0, poll_sel_i = 1'b0;
    logic        int_o, vec_valid_o;
    logic [7:0]  vec_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ivg_ack_vector u0 (
        .clk(clk), .rst(rst), .irq_i(irq_i), .m_imr_i(m_imr_i), .s_imr_i(s_imr_i),
        .m_base_i(m_base_i), .s_base_i(s_base_i), .aeoi_i(aeoi_i),
        .rot_aeoi_i(rot_aeoi_i), .tm_we_i(tm_we_i), .tm_sel_i(tm_sel_i),
        .tm_wdata_i(tm_wdata_i), .ack_i(ack_i), .poll_i(poll_i),
        .poll_sel_i(poll_sel_i), .int_o(int_o), .vec_o(vec_o),
        .vec_valid_o(vec_valid_o)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(input logic [1:0] ae, input logic [1:0] ro,
                           input logic [7:0] mm, input logic [7:0] sm);
        @(negedge clk);
        rst = 1'b1; irq_i = '0; aeoi_i = ae; rot_aeoi_i = ro;
        m_imr_i = mm; s_imr_i = sm;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic tm_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        tm_we_i = 1'b1; tm_sel_i = sel; tm_wdata_i = d;
        @(negedge clk);
        tm_we_i = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] bits);
        @(negedge clk);
        irq_i = irq_i | bits;
        @(negedge clk);
        irq_i = irq_i & ~bits;
    endtask

    task automatic do_ack(input string req, input int exp);
        @(negedge clk);
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        chk({req, " strobe"}, int'(vec_valid_o), 1);
        chk({req, " vector"}, int'(vec_o), exp);
    endtask

    task automatic do_poll(input string req, input logic sel, input int exp);
        @(negedge clk);
        poll_i = 1'b1; poll_sel_i = sel;
        @(negedge clk);
        poll_i = 1'b0;
        chk({req, " poll"}, int'(vec_o), exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        irq_i = 16'hFFFF;
        cyc(3);
        chk("R1 int", int'(int_o), 0);
        chk("R1 valid", int'(vec_valid_o), 0);
        chk("R1 vec", int'(vec_o), 0);
        irq_i = '0;
    endtask

    task automatic t_basic;
        restart(2'b01, 2'b00, 8'h00, 8'h00);
        pulse(16'h0040);
        cyc(2);
        chk("R12 int raised", int'(int_o), 1);
        do_ack("R2 master line6", 8'h0E);
        cyc(1);
        chk("R2 strobe drops", int'(vec_valid_o), 0);
        chk("R7 edge cleared int", int'(int_o), 0);
    endtask

    task automatic t_priority;
        restart(2'b00, 2'b00, 8'h00, 8'h00);
        pulse(16'h0050);
        cyc(2);
        do_ack("R3 line4 first", 8'h0C);
        cyc(2);
        chk("R3 isr blocks line6", int'(int_o), 0);
        do_ack("R4 master spurious", 8'h0F);
        pulse(16'h0008);
        cyc(2);
        chk("R3 preempt int", int'(int_o), 1);
        do_ack("R3 line3 preempts", 8'h0B);
    endtask

    task automatic t_aeoi;
        restart(2'b01, 2'b00, 8'h00, 8'h00);
        pulse(16'h0050);
        cyc(2);
        do_ack("R8 line4", 8'h0C);
        do_ack("R8 line6 not blocked", 8'h0E);
    endtask

    task automatic t_level;
        restart(2'b01, 2'b00, 8'h00, 8'h00);
        tm_write(1'b0, 8'hFF);
        @(negedge clk);
        irq_i = 16'h0022;
        cyc(3);
        do_ack("R10 line1 stays edge", 8'h09);
        do_ack("R7 level line5", 8'h0D);
        do_ack("R7 level line5 kept", 8'h0D);
        irq_i = '0;
        cyc(3);
        chk("R7 level drop int", int'(int_o), 0);
        do_ack("R4 after level drop", 8'h0F);
    endtask

    task automatic t_rotate;
        restart(2'b01, 2'b01, 8'h00, 8'h00);
        tm_write(1'b0, 8'hFF);
        @(negedge clk);
        irq_i = 16'h0028;
        cyc(3);
        do_ack("R9 first line3", 8'h0B);
        do_ack("R9 rotated to line5", 8'h0D);
        do_ack("R9 wrap to line3", 8'h0B);
        irq_i = '0;
    endtask

    task automatic t_cascade;
        restart(2'b00, 2'b00, 8'h00, 8'h00);
        pulse(16'h0200);
        cyc(4);
        chk("R5 cascade int", int'(int_o), 1);
        do_ack("R5 slave line1", 8'h71);
        cyc(2);
        chk("R5 int after cascade ack", int'(int_o), 0);
        pulse(16'h0100);
        cyc(4);
        chk("R5 master isr2 blocks", int'(int_o), 0);
    endtask

    task automatic t_slave_spur;
        restart(2'b00, 2'b00, 8'h00, 8'h00);
        tm_write(1'b1, 8'h08);
        @(negedge clk);
        irq_i = 16'h0800;
        cyc(4);
        irq_i = '0;
        cyc(3);
        chk("R6 latched cascade int", int'(int_o), 1);
        do_ack("R6 slave spurious", 8'h77);
    endtask

    task automatic t_poll;
        restart(2'b11, 2'b00, 8'h04, 8'h00);
        tm_write(1'b1, 8'hFF);
        @(negedge clk);
        irq_i = 16'h0300;
        cyc(3);
        do_poll("R11 R10 slave line0", 1'b1, 8'h80);
        do_poll("R11 R10 slave line1 level", 1'b1, 8'h81);
        do_poll("R11 slave line1 again", 1'b1, 8'h81);
        do_poll("R11 master empty", 1'b0, 8'h07);
        irq_i = '0;
        pulse(16'h0001);
        cyc(2);
        @(negedge clk);
        ack_i = 1'b1; poll_i = 1'b1; poll_sel_i = 1'b0;
        @(negedge clk);
        ack_i = 1'b0; poll_i = 1'b0;
        chk("R11 ack wins", int'(vec_o), 8'h08);
        do_poll("R11 consumed by ack", 1'b0, 8'h07);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_priority();
        t_aeoi();
        t_level();
        t_rotate();
        t_cascade();
        t_slave_spur();
        t_poll();
        cyc(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule